// File: doc/BRIEF.md
# Channel-Mapped Prioritized Interrupt Controller

This block collects up to 64 interrupt sources. Each source is first conditioned as a level or an edge of a chosen polarity and then held in a pending bit. A pending source that software has enabled is steered, through its own channel number, onto one of 32 ranked channels. The lowest channels drive a fast-interrupt line and the rest drive a normal-interrupt line. A global enable and one enable per host gate both lines.

Software reaches the block over a simple register bus. Each access takes one cycle: a write lands on the next clock edge and a read returns data combinationally. Single-bit updates are atomic, because software writes a source number to an indexed set or clear register. Word-wide write-one-to-clear registers clear many bits at once. For each host, software can read the number of the winning source instead of scanning the status words.

Top module: `irq_chan_ctrl`

## Requirements
- R1: After reset both host outputs are low. The global enable, host enables, source enables, pending bits, type bits and map bytes all read 0. The polarity words read 0xFFFFFFFF. Both winner registers read 0x8000_0000.
- R2: Type bits are at word address 0x20+w and polarity bits at 0x24+w, bit s%32 of word s/32. Type 1 selects edge and type 0 selects level. Polarity 1 selects rising or high, and polarity 0 selects falling or low.
- R3: In level mode, the pending bit (read at 0x18+w) shows the qualified input as sampled on the previous clock edge. Software clears have no effect on it.
- R4: In edge mode, a qualifying edge sets the pending bit one edge later, and the bit stays set until software clears it. When an edge arrives in the same cycle as a clear, the edge wins.
- R5: Writing a source number to 0x03 clears only that source's pending bit. A value of 64 or more changes nothing.
- R6: Writing a source number to 0x01 sets only that source's enable bit, and writing it to 0x02 clears only that bit. Enable words read at 0x10+w. Values of 64 or more are ignored.
- R7: Writing to 0x14+w clears the enable bits written as 1, and writing to 0x1C+w clears the pending bits written as 1. Bits written as 0 keep their value.
- R8: Map register 0x40+m holds the channel numbers of sources 4m to 4m+3. Source 4m+b uses bits 8b+4:8b, and bits 8b+7:8b+5 read 0.
- R9: The winner register 0x60 (fast host) or 0x61 (normal host) returns the enabled, pending source with the lowest channel in that host's range. Equal channels go to the lower source number. When no such source exists, the register reads 0x8000_0000.
- R10: Enabled pending sources on channels 0 and 1 raise `fiq_o`, and those on channels 2 to 31 raise `irq_o`. Disabled sources raise neither output.
- R11: Bit 0 of 0x00 is the global enable and gates both outputs. Writing a host number (0 for fast, 1 for normal) to 0x04 or 0x05 sets or clears that host's enable. Address 0x06 reads the host enables in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt source inputs |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| fiq_o | output | 1 | Fast-interrupt host line |
| irq_o | output | 1 | Normal-interrupt host line |

## Verification
The conditioning logic is driven with all four mode encodings. In each case the pulse that sets a bit is paired with a pulse of the opposite direction, to show that the wrong edge is ignored and that a level bit cannot be held by software. Status and enables are changed by indexed writes, one of them out of range, and by word writes with mixed ones and zeros, which shows that only the named bits move. The routing scenario puts several active sources on shared and distinct channels, in both host ranges. It shows that a lower channel beats a lower source number, that equal channels fall back to source number, and that disabled sources are invisible to both lines.

// File: rtl/irq_chan_pkg.sv
package irq_chan_pkg;
  localparam int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_GLB       = 8'h00;
  localparam addr_t A_ENA_ISET  = 8'h01;
  localparam addr_t A_ENA_ICLR  = 8'h02;
  localparam addr_t A_STAT_ICLR = 8'h03;
  localparam addr_t A_HEN_ISET  = 8'h04;
  localparam addr_t A_HEN_ICLR  = 8'h05;
  localparam addr_t A_HEN       = 8'h06;
  localparam addr_t A_ENA       = 8'h10;
  localparam addr_t A_ENA_WCLR  = 8'h14;
  localparam addr_t A_STAT      = 8'h18;
  localparam addr_t A_STAT_WCLR = 8'h1C;
  localparam addr_t A_TYPE      = 8'h20;
  localparam addr_t A_POL       = 8'h24;
  localparam addr_t A_MAP       = 8'h40;
  localparam addr_t A_PRI       = 8'h60;

  localparam int N_HOST = 2;
  localparam logic [31:0] PRI_NONE = 32'h8000_0000;
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int N_SRC = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] type_i,
  input  logic [N_SRC-1:0] pol_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] src_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic rise, fall, hit_edge, hit_lvl;
    assign rise     = src_i[i] & ~src_q[i];
    assign fall     = ~src_i[i] & src_q[i];
    assign hit_edge = pol_i[i] ? rise : fall;
    assign hit_lvl  = ~(src_i[i] ^ pol_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[i]  <= 1'b0;
        pend_o[i] <= 1'b0;
      end else begin
        src_q[i] <= src_i[i];
        // edge set beats a same-cycle clear
        if (type_i[i]) pend_o[i] <= (pend_o[i] & ~clr_i[i]) | hit_edge;
        else           pend_o[i] <= hit_lvl;
      end
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC  = 64,
  parameter int N_CHAN = 32,
  parameter int CH_LO  = 0,
  parameter int CH_HI  = 1,
  localparam int SW = $clog2(N_SRC),
  localparam int CW = $clog2(N_CHAN)
) (
  input  logic [N_SRC-1:0] act_i,
  input  logic [CW-1:0]    chan_i [N_SRC],
  output logic             hit_o,
  output logic [SW-1:0]    idx_o
);
  int best_c;

  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    best_c = CH_HI;
    for (int i = 0; i < N_SRC; i++) begin
      if (act_i[i] && int'(chan_i[i]) >= CH_LO && int'(chan_i[i]) <= CH_HI &&
          (!hit_o || int'(chan_i[i]) < best_c)) begin
        hit_o  = 1'b1;
        idx_o  = SW'(i);
        best_c = int'(chan_i[i]);
      end
    end
  end
endmodule

// File: rtl/irq_chan_ctrl.sv
module irq_chan_ctrl
  import irq_chan_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int N_CHAN = 32,
  parameter int N_FAST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int NW = N_SRC / 32;
  localparam int NM = N_SRC / 4;
  localparam int SW = $clog2(N_SRC);
  localparam int CW = $clog2(N_CHAN);

  logic              glb_en_q;
  logic [N_HOST-1:0] hen_q;
  logic [N_SRC-1:0]  ena_q, type_q, pol_q, pend_q;
  logic [CW-1:0]     chan_q [N_SRC];
  logic [N_SRC-1:0]  ena_set, ena_clr, st_clr;
  logic              idx_ok;
  logic [SW-1:0]     idx;
  logic [N_HOST-1:0] hit;
  logic [SW-1:0]     best [N_HOST];

  assign idx_ok = bus_wdata_i < 32'(N_SRC);
  assign idx    = bus_wdata_i[SW-1:0];

  always_comb begin
    ena_set = '0;
    ena_clr = '0;
    st_clr  = '0;
    if (bus_we_i && idx_ok) begin
      if (bus_addr_i == A_ENA_ISET)  ena_set[idx] = 1'b1;
      if (bus_addr_i == A_ENA_ICLR)  ena_clr[idx] = 1'b1;
      if (bus_addr_i == A_STAT_ICLR) st_clr[idx]  = 1'b1;
    end
    for (int w = 0; w < NW; w++) begin
      if (bus_we_i && bus_addr_i == A_ENA_WCLR + 8'(w))  ena_clr[w*32 +: 32] = bus_wdata_i;
      if (bus_we_i && bus_addr_i == A_STAT_WCLR + 8'(w)) st_clr[w*32 +: 32]  = bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_q <= 1'b0;
      hen_q    <= '0;
      ena_q    <= '0;
      type_q   <= '0;
      pol_q    <= '1;
      for (int i = 0; i < N_SRC; i++) chan_q[i] <= '0;
    end else begin
      ena_q <= (ena_q | ena_set) & ~ena_clr;
      if (bus_we_i) begin
        if (bus_addr_i == A_GLB) glb_en_q <= bus_wdata_i[0];
        if (bus_addr_i == A_HEN_ISET && bus_wdata_i < 32'(N_HOST)) hen_q[bus_wdata_i[0]] <= 1'b1;
        if (bus_addr_i == A_HEN_ICLR && bus_wdata_i < 32'(N_HOST)) hen_q[bus_wdata_i[0]] <= 1'b0;
        for (int w = 0; w < NW; w++) begin
          if (bus_addr_i == A_TYPE + 8'(w)) type_q[w*32 +: 32] <= bus_wdata_i;
          if (bus_addr_i == A_POL + 8'(w))  pol_q[w*32 +: 32]  <= bus_wdata_i;
        end
        for (int m = 0; m < NM; m++) begin
          if (bus_addr_i == A_MAP + 8'(m))
            for (int b = 0; b < 4; b++) chan_q[m*4+b] <= bus_wdata_i[b*8 +: CW];
        end
      end
    end
  end

  irq_src_cond #(.N_SRC(N_SRC)) u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .type_i (type_q),
    .pol_i  (pol_q),
    .clr_i  (st_clr),
    .pend_o (pend_q)
  );

  for (genvar h = 0; h < N_HOST; h++) begin : g_host
    localparam int LO = (h == 0) ? 0 : N_FAST;
    localparam int HI = (h == 0) ? N_FAST - 1 : N_CHAN - 1;
    irq_prio_pick #(.N_SRC(N_SRC), .N_CHAN(N_CHAN), .CH_LO(LO), .CH_HI(HI)) u_pick (
      .act_i  (pend_q & ena_q),
      .chan_i (chan_q),
      .hit_o  (hit[h]),
      .idx_o  (best[h])
    );
  end

  assign fiq_o = glb_en_q & hen_q[0] & hit[0];
  assign irq_o = glb_en_q & hen_q[1] & hit[1];

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_GLB) bus_rdata_o[0] = glb_en_q;
    if (bus_addr_i == A_HEN) bus_rdata_o[N_HOST-1:0] = hen_q;
    for (int w = 0; w < NW; w++) begin
      if (bus_addr_i == A_ENA + 8'(w))  bus_rdata_o = ena_q[w*32 +: 32];
      if (bus_addr_i == A_STAT + 8'(w)) bus_rdata_o = pend_q[w*32 +: 32];
      if (bus_addr_i == A_TYPE + 8'(w)) bus_rdata_o = type_q[w*32 +: 32];
      if (bus_addr_i == A_POL + 8'(w))  bus_rdata_o = pol_q[w*32 +: 32];
    end
    for (int m = 0; m < NM; m++) begin
      if (bus_addr_i == A_MAP + 8'(m))
        for (int b = 0; b < 4; b++) bus_rdata_o[b*8 +: CW] = chan_q[m*4+b];
    end
    for (int h = 0; h < N_HOST; h++) begin
      if (bus_addr_i == A_PRI + 8'(h)) bus_rdata_o = hit[h] ? 32'(best[h]) : PRI_NONE;
    end
  end
endmodule

// File: rtl/irq_chan_chk.sv
module irq_chan_chk
  import irq_chan_pkg::*;
#(
  parameter int N_SRC = 64,
  localparam int SW = $clog2(N_SRC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  src_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic              fiq_o,
  input logic              irq_o,
  input logic              glb_en_q,
  input logic [N_HOST-1:0] hen_q,
  input logic [N_SRC-1:0]  ena_q,
  input logic [N_SRC-1:0]  type_q,
  input logic [N_SRC-1:0]  pol_q,
  input logic [N_SRC-1:0]  pend_q
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_FIQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> glb_en_q && hen_q[0]); // R11
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> glb_en_q && hen_q[1]); // R11
  AST_HOST_ISET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == A_HEN_ISET && bus_wdata_i == 32'd1 |=> hen_q[1]); // R11
  AST_ENA_ISET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == A_ENA_ISET && bus_wdata_i < 32'(N_SRC)
    |=> ena_q[$past(bus_wdata_i[SW-1:0])]); // R6
  AST_LINE_NEEDS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_o || irq_o) |-> |(pend_q & ena_q)); // R10
  AST_WINNER_SHOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == A_PRI && fiq_o |-> !bus_rdata_o[31]); // R9

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && $past(type_q[i]) && $fell(pend_q[i]) |->
      $past(bus_we_i && ((bus_addr_i == A_STAT_ICLR && bus_wdata_i == 32'(i)) ||
                         (bus_addr_i == A_STAT_WCLR + 8'(i / 32) && bus_wdata_i[i % 32])))); // R4
    AST_LEVEL_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && $past(!type_q[i]) |-> pend_q[i] == $past(src_i[i] ~^ pol_q[i])); // R3
  end
endmodule

bind irq_chan_ctrl irq_chan_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .fiq_o       (fiq_o),
  .irq_o       (irq_o),
  .glb_en_q    (glb_en_q),
  .hen_q       (hen_q),
  .ena_q       (ena_q),
  .type_q      (type_q),
  .pol_q       (pol_q),
  .pend_q      (pend_q)
);

// File: tb/sim_irq_chan_ctrl.sv
module sim_irq_chan_ctrl;
  import irq_chan_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq, irq;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_chan_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk);
    src[i] = v;
    @(negedge clk);
  endtask

  task automatic out_chk(input logic ef, input logic ei, input string req);
    @(negedge clk);
    #1;
    chk({req, " fiq"}, {31'b0, fiq}, {31'b0, ef});
    chk({req, " irq"}, {31'b0, irq}, {31'b0, ei});
  endtask

  task automatic t_reset;
    out_chk(1'b0, 1'b0, "R1");
    rd_chk(A_GLB, 32'h0, "R1");
    rd_chk(A_HEN, 32'h0, "R1");
    rd_chk(A_ENA, 32'h0, "R1");
    rd_chk(A_STAT + 8'd1, 32'h0, "R1");
    rd_chk(A_TYPE, 32'h0, "R1");
    rd_chk(A_POL + 8'd1, 32'hFFFF_FFFF, "R1");
    rd_chk(A_MAP, 32'h0, "R1");
    rd_chk(A_PRI, PRI_NONE, "R1");
    rd_chk(A_PRI + 8'd1, PRI_NONE, "R1");
  endtask

  task automatic t_level;
    set_src(3, 1'b1);
    rd_chk(A_STAT, 32'h8, "R3 level high follows");
    wr(A_STAT_ICLR, 32'd3);
    rd_chk(A_STAT, 32'h8, "R3 index clear no effect");
    wr(A_STAT_WCLR, 32'h8);
    rd_chk(A_STAT, 32'h8, "R3 word clear no effect");
    set_src(3, 1'b0);
    rd_chk(A_STAT, 32'h0, "R3 level drop");
    wr(A_POL, 32'hFFFF_FFF7);
    rd_chk(A_STAT, 32'h8, "R2 active low");
    wr(A_POL, 32'hFFFF_FFFF);
    rd_chk(A_STAT, 32'h0, "R2 back to high");
  endtask

  task automatic t_edge;
    wr(A_TYPE, 32'h60);
    wr(A_POL, 32'hFFFF_FFBF);
    set_src(5, 1'b1);
    set_src(5, 1'b0);
    rd_chk(A_STAT, 32'h20, "R4 rising held");
    set_src(6, 1'b1);
    rd_chk(A_STAT, 32'h20, "R2 falling ignores rise");
    set_src(6, 1'b0);
    rd_chk(A_STAT, 32'h60, "R2 falling edge");
    // clear and new edge in one cycle
    @(negedge clk);
    src[5] = 1'b1; we = 1'b1; addr = A_STAT_ICLR; wdata = 32'd5;
    @(negedge clk);
    we = 1'b0;
    rd_chk(A_STAT, 32'h60, "R4 edge beats clear");
    wr(A_STAT_ICLR, 32'd5);
    rd_chk(A_STAT, 32'h40, "R5 index clear one bit");
    set_src(5, 1'b0);
    wr(A_STAT_ICLR, 32'd70);
    rd_chk(A_STAT, 32'h40, "R5 out of range ignored");
  endtask

  task automatic t_enable;
    wr(A_ENA_ISET, 32'd7);
    wr(A_ENA_ISET, 32'd40);
    wr(A_ENA_ISET, 32'd72);
    rd_chk(A_ENA, 32'h80, "R6 set low word");
    rd_chk(A_ENA + 8'd1, 32'h100, "R6 set high word");
    wr(A_ENA_ICLR, 32'd7);
    rd_chk(A_ENA, 32'h0, "R6 clear one");
    rd_chk(A_ENA + 8'd1, 32'h100, "R6 other kept");
  endtask

  task automatic t_w1c;
    wr(A_ENA_ISET, 32'd1);
    wr(A_ENA_ISET, 32'd2);
    wr(A_ENA_WCLR, 32'h2);
    rd_chk(A_ENA, 32'h4, "R7 enable word clear");
    rd_chk(A_ENA + 8'd1, 32'h100, "R7 other word kept");
    wr(A_ENA_WCLR + 8'd1, 32'h100);
    rd_chk(A_ENA + 8'd1, 32'h0, "R7 high word clear");
    set_src(5, 1'b1);
    set_src(5, 1'b0);
    rd_chk(A_STAT, 32'h60, "R7 pre");
    wr(A_STAT_WCLR, 32'h20);
    rd_chk(A_STAT, 32'h40, "R7 status word clear");
    wr(A_STAT_WCLR, 32'h40);
    rd_chk(A_STAT, 32'h0, "R7 status empty");
    wr(A_ENA_WCLR, 32'hFFFF_FFFF);
    wr(A_TYPE, 32'h0);
    wr(A_POL, 32'hFFFF_FFFF);
  endtask

  task automatic t_map;
    wr(A_MAP + 8'd1, 32'hFF03_1F21);
    rd_chk(A_MAP + 8'd1, 32'h1F03_1F01, "R8 byte layout");
    rd_chk(A_MAP, 32'h0, "R8 neighbour kept");
  endtask

  task automatic t_route;
    wr(A_MAP + 8'd2, 32'h0005_0000);   // src10 -> ch5
    wr(A_MAP + 8'd3, 32'h0000_0001);   // src12 -> ch1
    wr(A_MAP + 8'd5, 32'h0000_0003);   // src20 -> ch3
    wr(A_MAP + 8'd7, 32'h0003_0000);   // src30 -> ch3
    wr(A_MAP + 8'd12, 32'h0001_0000);  // src50 -> ch1
    wr(A_GLB, 32'd1);
    wr(A_HEN_ISET, 32'd0);
    wr(A_HEN_ISET, 32'd1);
    wr(A_ENA_ISET, 32'd10);
    wr(A_ENA_ISET, 32'd20);
    wr(A_ENA_ISET, 32'd30);
    set_src(11, 1'b1);                  // ch0 but disabled
    out_chk(1'b0, 1'b0, "R10 disabled ignored");
    set_src(30, 1'b1);
    set_src(20, 1'b1);
    set_src(10, 1'b1);
    out_chk(1'b0, 1'b1, "R10 normal only");
    rd_chk(A_PRI + 8'd1, 32'd20, "R9 tie lower source");
    rd_chk(A_PRI, PRI_NONE, "R9 fast empty");
    wr(A_ENA_ISET, 32'd50);
    set_src(50, 1'b1);
    out_chk(1'b1, 1'b1, "R10 fast line");
    rd_chk(A_PRI, 32'd50, "R9 fast winner");
    wr(A_ENA_ISET, 32'd12);
    set_src(12, 1'b1);
    rd_chk(A_PRI, 32'd12, "R9 tie in ch1");
    wr(A_MAP + 8'd12, 32'h0);
    rd_chk(A_PRI, 32'd50, "R9 lower channel wins");
    set_src(20, 1'b0);
    rd_chk(A_PRI + 8'd1, 32'd30, "R9 next in ch3");
  endtask

  task automatic t_gate;
    wr(A_HEN_ICLR, 32'd0);
    out_chk(1'b0, 1'b1, "R11 fast host off");
    rd_chk(A_HEN, 32'h2, "R11 host enable read");
    wr(A_GLB, 32'd0);
    out_chk(1'b0, 1'b0, "R11 global off");
    wr(A_GLB, 32'd1);
    wr(A_HEN_ISET, 32'd0);
    out_chk(1'b1, 1'b1, "R11 all on");
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_level();
    t_edge();
    t_enable();
    t_w1c();
    t_map();
    t_route();
    t_gate();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule